// File: doc/BRIEF.md
# Low-Voltage Reset Sequencer

This block is the digital controller that sits behind the supply-monitor comparators of a chip. It takes the result of the power-on re-arm comparator and of two low-voltage trip comparators (a high and a low trip level). It drives the system reset and tells the rest of the chip which source caused the most recent reset. A deep dip of the supply below the re-arm level resets the chip at once. The reset is then held until the supply is reliably above the low trip level. While the chip runs, a configurable low-voltage detector can pull the reset again if the supply sags below the chosen trip level.

The trip comparator levels are filtered: a level must persist for a set number of clocks before the sequencer acts on it. Each comparator has its own filter. After a low-voltage trip, the reset is released once the selected comparator again reports a good supply, and then only after a further fixed settling count.

The block also handles stop requests. It reports which stop depth the chip enters and switches the comparator off in the deep stop depths. When software has asked for low-voltage detection to stay alive through stop, the requested depth is raised to the shallower stop depth 4, where the detector keeps running.

Top module: `lvr_seq`

## Requirements
- R1: While `below_rearm_i` is 1, `sys_rst_o` is 1 in the same cycle, without waiting for a clock edge. The configuration returns to its defaults: detector enabled, keep-in-stop off, low trip level selected.
- R2: After a re-arm reset, `sys_rst_o` stays 1 until the filtered low-level comparator reads 1, whatever the trip select holds. `sys_rst_o` falls FILT+1 cycles after `above_lo_i` rises.
- R3: Both `src_por_o` and `src_lvd_o` are set after a re-arm reset or after `rst_n` is asserted.
- R4: A low-voltage trip happens only while the detector enable bit is 1. The trip select bit set to 1 uses `above_hi_i`; set to 0 it uses `above_lo_i`.
- R5: A low-voltage trip sets `src_lvd_o` to 1 and clears `src_por_o`. `sys_rst_o` rises FILT+1 cycles after the selected comparator falls.
- R6: A comparator level that lasts fewer than FILT consecutive cycles has no effect.
- R7: After a low-voltage trip, `sys_rst_o` falls FILT+1+DLY cycles after the selected comparator returns to 1.
- R8: One cycle after `stop_req_i` rises while running, `stop_mode_o` shows the stop depth, encoded 2 for stop2 and 3 for stop3. `stop_depth_i`=0 requests stop2 and `stop_depth_i`=1 requests stop3. If both the detector enable and keep-in-stop are 1, `stop_mode_o` shows 4 instead. `stop_mode_o` returns to 0 one cycle after `stop_req_i` falls.
- R9: In stop2 or stop3, `cmp_en_o` is 0 and no low-voltage trip occurs. In stop4, `cmp_en_o` is 1 and trips still occur. While running outside stop, `cmp_en_o` equals the detector enable bit.
- R10: Any reset clears `stop_mode_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, treated as power-up |
| below_rearm_i | input | 1 | 1 = supply below the power-on re-arm level |
| above_lo_i | input | 1 | 1 = supply above the low trip level |
| above_hi_i | input | 1 | 1 = supply above the high trip level |
| stop_req_i | input | 1 | Level: stop requested |
| stop_depth_i | input | 1 | Requested stop depth, 0 = stop2, 1 = stop3 |
| cfg_we_i | input | 1 | Write strobe for the three configuration bits |
| cfg_det_en_i | input | 1 | Write data: detector enable |
| cfg_stop_keep_i | input | 1 | Write data: keep detector alive in stop |
| cfg_sel_hi_i | input | 1 | Write data: 1 = high trip level, 0 = low |
| sys_rst_o | output | 1 | System reset, active high |
| cmp_en_o | output | 1 | Comparator enable |
| stop_mode_o | output | 3 | 0 run, 2 stop2, 3 stop3, 4 stop4 |
| src_por_o | output | 1 | Sticky re-arm reset source bit |
| src_lvd_o | output | 1 | Sticky low-voltage reset source bit |

## Verification
The bench selects the high trip level and then raises only the low comparator. This checks that release from power-on depends on the low level alone, and that a detector which then samples the high level trips at once. A design that used the selected level for power-on release would never leave reset here.

A comparator pulse one cycle short of the filter length is sent, along with a supply dip during stop2. A weak filter, or a detector that is not gated in deep stop, would pulse the reset in these cases.

A stop request with both enables set must report stop4, and a trip must then clear the mode. The release after a trip is counted to the exact cycle, so a missing settling delay shows as an early release. A missing source-bit clear shows as a stale power-on flag. A re-arm reset at the end must restore the low trip level, so the chip then runs with the high comparator still low.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  typedef enum logic [1:0] {
    ST_POR = 2'd0,
    ST_LVD = 2'd1,
    ST_DLY = 2'd2,
    ST_RUN = 2'd3
  } lvr_state_e;

  typedef struct packed {
    logic det_en;
    logic keep;
    logic sel_hi;
  } lvr_cfg_t;

  localparam lvr_cfg_t CFG_DEF = '{det_en: 1'b1, keep: 1'b0, sel_hi: 1'b0};

  localparam logic [2:0] MODE_RUN = 3'd0;
  localparam logic [2:0] MODE_S2  = 3'd2;
  localparam logic [2:0] MODE_S3  = 3'd3;
  localparam logic [2:0] MODE_S4  = 3'd4;
endpackage

// File: rtl/lvr_filt.sv
module lvr_filt #(
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = $clog2(FILT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q, flt_d;

  always_comb begin
    cnt_d = cnt_q;
    flt_d = flt_q;
    if (clr_i) begin
      cnt_d = '0;
      flt_d = 1'b0;
    end else if (raw_i != flt_q) begin
      if (cnt_q == CW'(FILT - 1)) begin
        cnt_d = '0;
        flt_d = raw_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign flt_o = flt_q;

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && raw_i == flt_q) |=> (flt_q == $past(flt_q))); // R6
endmodule

// File: rtl/lvr_cfg.sv
module lvr_cfg
  import lvr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     we_i,
  input  lvr_cfg_t wdata_i,
  output lvr_cfg_t cfg_o
);
  lvr_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (clr_i)     cfg_d = CFG_DEF;
    else if (we_i) cfg_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_DEF;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_CFG_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cfg_q == CFG_DEF)); // R1
endmodule

// File: rtl/lvr_fsm.sv
module lvr_fsm
  import lvr_pkg::*;
#(
  parameter int DLY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_i,
  input  logic       lo_f_i,
  input  logic       hi_f_i,
  input  lvr_cfg_t   cfg_i,
  input  logic       stop_req_i,
  input  logic       stop_depth_i,
  output logic       hold_o,
  output logic       cmp_en_o,
  output logic [2:0] mode_o,
  output logic       src_por_o,
  output logic       src_lvd_o
);
  localparam int DW = $clog2(DLY + 1);

  lvr_state_e    state_q, state_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [2:0]    mode_q, mode_d;
  logic          por_q, por_d, lvd_q, lvd_d;
  logic          sel_f, deep, trip;

  assign sel_f = cfg_i.sel_hi ? hi_f_i : lo_f_i;
  assign deep  = (mode_q == MODE_S2) || (mode_q == MODE_S3);
  assign trip  = (state_q == ST_RUN) && cfg_i.det_en && !deep && !sel_f;

  always_comb begin
    state_d = state_q;
    dcnt_d  = dcnt_q;
    case (state_q)
      ST_POR: if (lo_f_i) state_d = ST_RUN;
      ST_LVD: if (sel_f) begin
        state_d = ST_DLY;
        dcnt_d  = '0;
      end
      ST_DLY: begin
        if (!sel_f)                       state_d = ST_LVD;
        else if (dcnt_q == DW'(DLY - 1))  state_d = ST_RUN;
        else                              dcnt_d  = dcnt_q + 1'b1;
      end
      default: if (trip) state_d = ST_LVD;
    endcase
    if (below_i) state_d = ST_POR;
  end

  always_comb begin
    por_d = por_q;
    lvd_d = lvd_q;
    if (below_i) begin
      por_d = 1'b1;
      lvd_d = 1'b1;
    end else if (trip) begin
      por_d = 1'b0;
      lvd_d = 1'b1;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (below_i || trip || state_q != ST_RUN || !stop_req_i) begin
      mode_d = MODE_RUN;
    end else if (mode_q == MODE_RUN) begin
      if (cfg_i.det_en && cfg_i.keep) mode_d = MODE_S4;
      else if (stop_depth_i)          mode_d = MODE_S3;
      else                            mode_d = MODE_S2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR;
      dcnt_q  <= '0;
      mode_q  <= MODE_RUN;
      por_q   <= 1'b1;
      lvd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      dcnt_q  <= dcnt_d;
      mode_q  <= mode_d;
      por_q   <= por_d;
      lvd_q   <= lvd_d;
    end
  end

  always_comb begin
    if (state_q != ST_RUN)      cmp_en_o = 1'b1;
    else if (deep)              cmp_en_o = 1'b0;
    else if (mode_q == MODE_S4) cmp_en_o = 1'b1;
    else                        cmp_en_o = cfg_i.det_en;
  end

  assign hold_o    = (state_q != ST_RUN);
  assign mode_o    = mode_q;
  assign src_por_o = por_q;
  assign src_lvd_o = lvd_q;

  AST_POR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    below_i |=> (por_q && lvd_q && state_q == ST_POR)); // R3
  AST_POR_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POR && !lo_f_i) |=> (state_q != ST_RUN)); // R2
  AST_TRIP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LVD && $past(state_q) == ST_RUN) |-> (!por_q && lvd_q)); // R5
  AST_DEEP_NOTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && deep && !below_i) |=> (state_q == ST_RUN)); // R9
  AST_DLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DLY && !sel_f && !below_i) |=> (state_q == ST_LVD)); // R7
  AST_STOP4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && mode_q == MODE_RUN && stop_req_i && !trip && !below_i
     && cfg_i.det_en && cfg_i.keep) |=> (mode_q == MODE_S4)); // R8
  AST_RST_NOMODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> (mode_q == MODE_RUN)); // R10
endmodule

// File: rtl/lvr_seq.sv
module lvr_seq
  import lvr_pkg::*;
#(
  parameter int FILT = 4,
  parameter int DLY  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_rearm_i,
  input  logic       above_lo_i,
  input  logic       above_hi_i,
  input  logic       stop_req_i,
  input  logic       stop_depth_i,
  input  logic       cfg_we_i,
  input  logic       cfg_det_en_i,
  input  logic       cfg_stop_keep_i,
  input  logic       cfg_sel_hi_i,
  output logic       sys_rst_o,
  output logic       cmp_en_o,
  output logic [2:0] stop_mode_o,
  output logic       src_por_o,
  output logic       src_lvd_o
);
  localparam int NCMP = 2;

  logic [1:0]      rsync_q;
  logic            rst_s_n;
  logic [NCMP-1:0] raw, flt;
  lvr_cfg_t        wdata, cfg;
  logic            hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  assign raw = {above_hi_i, above_lo_i};

  for (genvar g = 0; g < NCMP; g++) begin : g_filt
    lvr_filt #(.FILT(FILT)) u_filt (
      .clk  (clk),
      .rst_n(rst_s_n),
      .clr_i(below_rearm_i),
      .raw_i(raw[g]),
      .flt_o(flt[g])
    );
  end

  assign wdata = '{det_en: cfg_det_en_i, keep: cfg_stop_keep_i, sel_hi: cfg_sel_hi_i};

  lvr_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr_i  (below_rearm_i),
    .we_i   (cfg_we_i),
    .wdata_i(wdata),
    .cfg_o  (cfg)
  );

  lvr_fsm #(.DLY(DLY)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .below_i     (below_rearm_i),
    .lo_f_i      (flt[0]),
    .hi_f_i      (flt[1]),
    .cfg_i       (cfg),
    .stop_req_i  (stop_req_i),
    .stop_depth_i(stop_depth_i),
    .hold_o      (hold),
    .cmp_en_o    (cmp_en_o),
    .mode_o      (stop_mode_o),
    .src_por_o   (src_por_o),
    .src_lvd_o   (src_lvd_o)
  );

  assign sys_rst_o = below_rearm_i | hold;

  AST_REARM_RST: assert property (@(posedge clk) disable iff (!rst_s_n)
    below_rearm_i |=> sys_rst_o); // R1
endmodule

// File: tb/lvr_seq_test.sv
`timescale 1ns/1ps
module lvr_seq_test;
  localparam int FILT = 4;
  localparam int DLY  = 16;

  localparam logic [6:0] M_RST  = 7'b1000000;
  localparam logic [6:0] M_CMP  = 7'b0100000;
  localparam logic [6:0] M_MODE = 7'b0011100;
  localparam logic [6:0] M_SRC  = 7'b0000011;
  localparam logic [6:0] M_ALL  = 7'b1111111;

  logic clk = 1'b0;
  logic rst_n;
  logic below, lo, hi, sreq, sdep, we, c_det, c_keep, c_sel;
  logic sys_rst, cmp_en, por, lvd;
  logic [2:0] mode;

  always #2 clk = ~clk;

  lvr_seq #(.FILT(FILT), .DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .below_rearm_i(below), .above_lo_i(lo),
    .above_hi_i(hi), .stop_req_i(sreq), .stop_depth_i(sdep), .cfg_we_i(we),
    .cfg_det_en_i(c_det), .cfg_stop_keep_i(c_keep), .cfg_sel_hi_i(c_sel),
    .sys_rst_o(sys_rst), .cmp_en_o(cmp_en), .stop_mode_o(mode),
    .src_por_o(por), .src_lvd_o(lvd)
  );

  typedef struct {
    int         cyc;
    string      req;
    logic [6:0] msk;
    logic [6:0] val;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [6:0] pk(logic r, logic c, logic [2:0] m, logic p, logic l);
    return {r, c, m, p, l};
  endfunction

  task automatic expect_at(int d, string req, logic [6:0] msk, logic [6:0] val);
    item_t it;
    it.cyc = cyc + d;
    it.req = req;
    it.msk = msk;
    it.val = val;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(logic d, logic k, logic s);
    we = 1'b1; c_det = d; c_keep = k; c_sel = s;
    step(1);
    we = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      logic [6:0] obs;
      obs = {sys_rst, cmp_en, mode, por, lvd};
      checks++;
      if (q[0].cyc != cyc || ((obs ^ q[0].val) & q[0].msk) != 7'b0) begin
        errors++;
        $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                 q[0].req, cyc, obs & q[0].msk, q[0].val & q[0].msk, q[0].msk);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; below = 0; lo = 0; hi = 0; sreq = 0; sdep = 0;
    we = 0; c_det = 0; c_keep = 0; c_sel = 0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R3 reset state: both source bits, held in reset, stop mode 0
    expect_at(0, "R3", M_ALL, pk(1, 1, 3'd0, 1, 1));
    step(2);

    // R6 short pulse on low comparator is ignored
    lo = 1; step(FILT - 1); lo = 0;
    expect_at(3, "R6", M_RST, M_RST);
    expect_at(8, "R6", M_RST, M_RST);
    step(10);

    // R2 release on low level even with high level selected; R4/R5 then trip
    wcfg(1, 0, 1);
    step(2);
    lo = 1;
    expect_at(FILT,     "R2", M_RST, M_RST);
    expect_at(FILT + 1, "R2", M_RST | M_SRC, pk(0, 0, 0, 1, 1));
    expect_at(FILT + 2, "R5", M_RST | M_SRC, pk(1, 0, 0, 0, 1));
    step(FILT + 4);

    // R7 release after selected level returns plus delay
    hi = 1;
    expect_at(FILT + DLY,     "R7", M_RST, M_RST);
    expect_at(FILT + DLY + 1, "R7", M_RST | M_SRC, pk(0, 0, 0, 0, 1));
    step(FILT + DLY + 4);

    // R8 stop2 request; R9 no trip in deep stop
    sdep = 0; sreq = 1;
    expect_at(1, "R8", M_MODE | M_CMP, pk(0, 0, 3'd2, 0, 0));
    step(2);
    hi = 0;
    expect_at(FILT + 4, "R9", M_RST | M_MODE | M_CMP, pk(0, 0, 3'd2, 0, 0));
    step(FILT + 6);
    hi = 1;
    step(FILT + 4);
    sreq = 0;
    expect_at(1, "R8", M_RST | M_MODE | M_CMP, pk(0, 1, 3'd0, 0, 0));
    step(3);

    // R8 promotion to stop4; R9 trip still active; R10 mode cleared on reset
    wcfg(1, 1, 1);
    step(2);
    sdep = 1; sreq = 1;
    expect_at(1, "R8", M_MODE | M_CMP, pk(0, 1, 3'd4, 0, 0));
    step(2);
    hi = 0;
    expect_at(FILT,     "R9", M_RST | M_MODE, pk(0, 0, 3'd4, 0, 0));
    expect_at(FILT + 1, "R10", M_RST | M_MODE | M_SRC, pk(1, 0, 3'd0, 0, 1));
    step(FILT + 3);
    sreq = 0;
    step(2);

    // R4 detector disabled: supply sag has no effect
    wcfg(0, 1, 1);
    step(1);
    hi = 1;
    expect_at(FILT + DLY + 1, "R7", M_RST, 7'b0);
    step(FILT + DLY + 4);
    lo = 0; hi = 0;
    expect_at(FILT + 6, "R4", M_RST | M_CMP, pk(0, 0, 0, 0, 0));
    step(FILT + 8);

    // R8 keep set but detector off: requested depth kept
    sdep = 0; sreq = 1;
    expect_at(1, "R8", M_MODE, pk(0, 0, 3'd2, 0, 0));
    step(2);
    sreq = 0;
    step(2);

    // R1 re-arm forces reset at once; R3 both source bits
    below = 1;
    expect_at(0, "R1", M_RST, M_RST);
    expect_at(1, "R3", M_RST | M_MODE | M_SRC, pk(1, 0, 3'd0, 1, 1));
    step(3);
    below = 0; lo = 1;
    expect_at(FILT,     "R2", M_RST, M_RST);
    expect_at(FILT + 1, "R2", M_RST, 7'b0);
    // R1 defaults restored: low level selected, detector on, no trip
    expect_at(FILT + 4, "R1", M_RST | M_CMP | M_SRC, pk(0, 1, 0, 1, 1));
    step(FILT + 7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule